// File: doc/BRIEF.md
# Input-Change Sequence Detector

This block watches a pair of level inputs, `x1` and `x2`, on a fast system clock. It reacts only when the pair changes value. Holding a value for any number of cycles does nothing. The block raises its output `z` when the pair moves through the ordered values 00, then 01, then 11. On the next change of the pair, whatever the new value, `z` drops again. It is the clocked version of a fundamental-mode detector: the inputs move one bit at a time and only while the machine is settled.

Each input passes through a short register chain. A change is found by comparing the newest registered pair with the pair held one clock earlier. The state register advances only on such a change. When both bits change together, the input is outside the legal input space. The machine then falls back to a non-detecting state and sets a sticky error flag. Only reset clears that flag.

Top module: `pairSeqDetect`

## Requirements
- R1: While reset is asserted and on the cycle after it is released, `z` is 0 and `badInput` is 0. A pair value already present during reset does not count as a fresh 00, so after reset the pair must change into 00 before any progress counts.
- R2: `z` goes to 1 when the pair changes to 01 directly after changing into 00, then changes to 11. Pair values are written as {x1,x2}.
- R3: While `z` is 1, the next change of the pair sets `z` to 0, whether the new value is 01, 10 or 00.
- R4: The path 00, 10, 11 never sets `z`.
- R5: Reaching 11 from an 01 that was not entered directly from 00 leaves `z` at 0. After such a path, or after a detection, the pair must pass through 00 again before the sequence can be detected.
- R6: After a detection, the route 11, 01, 00, 01, 11 detects the sequence again.
- R7: While the pair does not change, `z` keeps its value, however many cycles pass.
- R8: A change of both bits at once sets `badInput` to 1 and drives `z` to 0. A 00 reached by such a change does not arm the detector.
- R9: Once set, `badInput` stays 1 through any later input activity, including detections, until reset.
- R10: `z` changes exactly SYNC_STAGES+1 clock cycles after the input change that causes it. The input passes through SYNC_STAGES registers, and one more register holds the state and the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| x1 | input | 1 | First input bit (upper bit of the pair) |
| x2 | input | 1 | Second input bit (lower bit of the pair) |
| z | output | 1 | Registered detection output |
| badInput | output | 1 | Sticky flag: both inputs changed together |

## Verification
The assertions assume that every value of the pair is held for at least SYNC_STAGES+1 cycles, so that each change is seen as its own event. They also assume that the pair is steady across reset release. Only under these conditions does a registered change stand for a change at the pins. The stimulus waits eight cycles after each change and holds the pair constant around every reset. It makes two-bit changes only in the steps that test the illegal-input flag on purpose.

// File: rtl/pairSeqPkg.sv
package pairSeqPkg;

  // Flow-table rows of the detector
  typedef enum logic [1:0] {
    ST_WAIT_ZERO = 2'd0,  // not armed: needs a change into 00
    ST_GOT_ZERO  = 2'd1,  // pair entered 00
    ST_GOT_ONE   = 2'd2,  // pair moved 00 -> 01
    ST_HIT       = 2'd3   // pair moved 00 -> 01 -> 11, output high
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic zSet;
    logic zClear;
    logic flagBad;
  } seqStrobe_t;

  localparam logic [1:0] PAIR_ZERO = 2'b00;
  localparam logic [1:0] PAIR_STEP = 2'b01;
  localparam logic [1:0] PAIR_FULL = 2'b11;

endpackage

// File: rtl/pairSeqDatapath.sv
module pairSeqDatapath
  import pairSeqPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       x1,
  input  logic       x2,
  input  seqStrobe_t strobe,
  output logic [1:0] curPair,
  output logic [1:0] prevPair,
  output logic       evt,
  output logic       evtSingle,
  output logic       evtDouble,
  output logic       z,
  output logic       badInput
);

  localparam int CHAIN_W = 2 * SYNC_STAGES;
  localparam int FILL    = SYNC_STAGES + 1;
  localparam int CW      = $clog2(FILL + 1);
  localparam logic [CW-1:0] FILL_V = CW'(FILL);

  logic [CHAIN_W-1:0] syncQ;
  logic [CW-1:0]      fillCnt;
  logic               primed;

  // Input register chain; its depth is set by the parameter
  generate
    if (SYNC_STAGES == 1) begin : g_oneStage
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {x1, x2};
      end
    end else begin : g_multiStage
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {syncQ[CHAIN_W-3:0], x1, x2};
      end
    end
  endgenerate

  assign curPair = syncQ[CHAIN_W-1 -: 2];

  // Stay silent until the chain and the previous-value register have
  // both been filled with real input samples since reset
  always_ff @(posedge clk) begin
    if (rst)          fillCnt <= '0;
    else if (!primed) fillCnt <= fillCnt + 1'b1;
  end
  assign primed = (fillCnt == FILL_V);

  always_ff @(posedge clk) begin
    if (rst) prevPair <= '0;
    else     prevPair <= curPair;
  end

  assign evt       = primed && (curPair != prevPair);
  assign evtDouble = evt && (&(curPair ^ prevPair));
  assign evtSingle = evt && !evtDouble;

  // Registered output: no glitch while the state changes
  always_ff @(posedge clk) begin
    if (rst)              z <= 1'b0;
    else if (strobe.zSet) z <= 1'b1;
    else if (strobe.zClear) z <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                 badInput <= 1'b0;
    else if (strobe.flagBad) badInput <= 1'b1;
  end

endmodule

// File: rtl/pairSeqControl.sv
module pairSeqControl
  import pairSeqPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       evtSingle,
  input  logic       evtDouble,
  input  logic [1:0] curPair,
  output seqStrobe_t strobe
);

  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    if (evtDouble) begin
      stateD = ST_WAIT_ZERO;
    end else if (evtSingle) begin
      unique case (stateQ)
        ST_WAIT_ZERO: stateD = (curPair == PAIR_ZERO) ? ST_GOT_ZERO : ST_WAIT_ZERO;
        ST_GOT_ZERO:  stateD = (curPair == PAIR_STEP) ? ST_GOT_ONE  : ST_WAIT_ZERO;
        ST_GOT_ONE: begin
          if (curPair == PAIR_FULL)      stateD = ST_HIT;
          else if (curPair == PAIR_ZERO) stateD = ST_GOT_ZERO;
          else                           stateD = ST_WAIT_ZERO;
        end
        ST_HIT:       stateD = ST_WAIT_ZERO;
        default:      stateD = ST_WAIT_ZERO;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_WAIT_ZERO;
    else     stateQ <= stateD;
  end

  always_comb begin
    strobe.zSet    = evtSingle && (stateQ == ST_GOT_ONE) && (curPair == PAIR_FULL);
    strobe.zClear  = (evtSingle || evtDouble) && (stateQ == ST_HIT);
    strobe.flagBad = evtDouble;
  end

endmodule

// File: rtl/pairSeqDetect.sv
module pairSeqDetect
  import pairSeqPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic x1,
  input  logic x2,
  output logic z,
  output logic badInput
);

  seqStrobe_t strobe;
  logic [1:0] curPair;
  logic [1:0] prevPair;
  logic       evt;
  logic       evtSingle;
  logic       evtDouble;

  pairSeqDatapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .x1       (x1),
    .x2       (x2),
    .strobe   (strobe),
    .curPair  (curPair),
    .prevPair (prevPair),
    .evt      (evt),
    .evtSingle(evtSingle),
    .evtDouble(evtDouble),
    .z        (z),
    .badInput (badInput)
  );

  pairSeqControl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .evtSingle(evtSingle),
    .evtDouble(evtDouble),
    .curPair  (curPair),
    .strobe   (strobe)
  );

endmodule

// File: rtl/pairSeqDetectChecker.sv
module pairSeqDetectChecker (
  input logic       clk,
  input logic       rst,
  input logic       z,
  input logic       badInput,
  input logic       evt,
  input logic [1:0] curPair,
  input logic [1:0] prevPair
);

  logic rstQ = 1'b0;
  always_ff @(posedge clk) rstQ <= rst;

  // R1: outputs are cleared in the cycle after reset
  always @(posedge clk) begin
    if (rstQ) begin
      p_reset_clears_r1: assert (!z && !badInput)
        else $error("p_reset_clears_r1");
    end
  end

  // R2: z only rises after a change into 11
  p_rise_on_full_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(z) |-> ($past(evt) && $past(curPair) == 2'b11));

  // R3: any change while z is high drops z
  p_drop_on_change_r3: assert property (@(posedge clk) disable iff (rst)
    (z && evt) |=> !z);

  // R7: no change, no output movement
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !evt |=> $stable(z));

  // R8: a two-bit change flags the input and leaves z low
  p_double_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (evt && (curPair ^ prevPair) == 2'b11) |=> (badInput && !z));

  // R9: the flag is sticky until reset
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    badInput |=> badInput);

endmodule

bind pairSeqDetect pairSeqDetectChecker u_chk (
  .clk     (clk),
  .rst     (rst),
  .z       (z),
  .badInput(badInput),
  .evt     (evt),
  .curPair (curPair),
  .prevPair(prevPair)
);

// File: tb/pairSeqDetect_test.sv
`timescale 1ns/1ps
module pairSeqDetect_test;

  localparam int SYNC_STAGES = 2;
  localparam int SETTLE      = 8;
  localparam int NVEC        = 30;

  // Entry: {pair x1x2, expected z, expected badInput}; starts after reset with pair 00
  localparam logic [3:0] VEC [NVEC] = '{
    4'b01_0_0, 4'b11_0_0, 4'b01_0_0, 4'b00_0_0, 4'b01_0_0, // R1: reset-time 00 does not arm
    4'b11_1_0, 4'b10_0_0, 4'b00_0_0, 4'b10_0_0, 4'b11_0_0, // R2 hit, R3 drop, R4 path
    4'b01_0_0, 4'b11_0_0, 4'b01_0_0, 4'b00_0_0, 4'b01_0_0, // R5
    4'b11_1_0, 4'b01_0_0, 4'b11_0_0, 4'b01_0_0, 4'b00_0_0, // R6 hit, R3 drop, R5
    4'b01_0_0, 4'b11_1_0, 4'b00_0_1, 4'b01_0_1, 4'b11_0_1, // R8 double 11->00
    4'b01_0_1, 4'b00_0_1, 4'b01_0_1, 4'b11_1_1, 4'b10_0_1  // R9 sticky
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x1  = 1'b0;
  logic x2  = 1'b0;
  logic z;
  logic badInput;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pairSeqDetect #(.SYNC_STAGES(SYNC_STAGES)) uut (
    .clk(clk), .rst(rst), .x1(x1), .x2(x2), .z(z), .badInput(badInput)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drivePair(input logic [1:0] p, input int waitCycles);
    @(negedge clk);
    {x1, x2} = p;
    repeat (waitCycles) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 z in reset", z, 1'b0);
    chk("R1 badInput in reset", badInput, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 z after reset", z, 1'b0);
    chk("R1 badInput after reset", badInput, 1'b0);
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    doReset();

    // Table walk: R1..R6, R8, R9
    for (int i = 0; i < NVEC; i++) begin
      drivePair(VEC[i][3:2], SETTLE);
      chk($sformatf("R2-table step %0d z", i), z, VEC[i][1]);
      chk($sformatf("R8-table step %0d badInput", i), badInput, VEC[i][0]);
    end

    // R9: reset clears the sticky flag
    doReset();
    chk("R9 flag cleared by reset", badInput, 1'b0);

    // R10: exact latency, with the pair 01 at reset
    {x1, x2} = 2'b01;
    doReset();
    drivePair(2'b00, SETTLE);
    drivePair(2'b01, SETTLE);
    @(negedge clk);
    {x1, x2} = 2'b11;
    repeat (SYNC_STAGES) @(posedge clk);
    @(negedge clk);
    chk("R10 z before latency", z, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 z at latency", z, 1'b1);

    // R7: z held while the pair stays put
    repeat (50) @(negedge clk);
    chk("R7 z held", z, 1'b1);

    // R8: double change 11 -> 00 while high
    drivePair(2'b00, SETTLE);
    chk("R8 z dropped on double", z, 1'b0);
    chk("R8 badInput set", badInput, 1'b1);
    repeat (40) @(negedge clk);
    chk("R9 badInput sticky", badInput, 1'b1);

    // R1: reset while high returns to idle
    drivePair(2'b01, SETTLE);
    drivePair(2'b00, SETTLE);
    drivePair(2'b01, SETTLE);
    drivePair(2'b11, SETTLE);
    chk("R2 detect after flag", z, 1'b1);
    doReset();
    chk("R1 z cleared by reset while high", z, 1'b0);
    // R5: 01 -> 11 after reset without a fresh 00
    drivePair(2'b01, SETTLE);
    drivePair(2'b11, SETTLE);
    chk("R5 no detect without fresh 00", z, 1'b0);

    finishRun();
  end

endmodule